// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is a byte-wide register file for a standard parallel printer port, placed on a simple single-cycle host bus. The host reaches three registers through a 3-bit offset: a data latch at offset 0, a status register at offset 1 and a control register at offset 2. The printer itself is not attached through real pins. A small handshake model inside the block plays the printer's part instead. Control writes that raise the strobe hand the current data byte to a byte-valid output stream. Later status reads walk the busy and acknowledge bits through their sequence, the way a printer would answer.

The host drives an access for one cycle. Read data is combinational from the state held before the clock edge. Every state change takes effect at that edge. The interrupt line is a registered level. It rises after a control write that pulses the printer while interrupts are enabled. It falls after the next status read.

Top module: `ppc_port`

## Requirements
- R1: Only offsets 0 (data), 1 (status) and 2 (control) are decoded. A read of offsets 3 to 7 returns 0xFF. A write to offsets 1 or 3 to 7 leaves data, control, status and the interrupt unchanged.
- R2: A control write stores the written byte with bits 7 and 6 forced to one. A control read returns the stored byte. Control bit fields: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 init, 1 auto-linefeed, 0 strobe.
- R3: A control write with init (bit 2) clear loads status with 0xD8. In that value, bit 7 (not-busy), bit 6 (ack), bit 4 (online) and bit 3 (not-error) are set, and paper-out (bit 5) and timeout (bit 0) are clear.
- R4: A control write with init, select and strobe all set clears status bit 7. If the strobe bit of the previously stored control was clear, `tx_valid` pulses high for exactly the one cycle after the write, with the data latch on `tx_byte`. If that strobe bit was already set, nothing is emitted.
- R5: A control write with init and select set and strobe clear sets the pending interrupt when the previously stored control has interrupt enable (bit 4) set. `irq` is high from the cycle after that write.
- R6: A status read returns the current status byte, and `irq` is low from the cycle after the read.
- R7: A status read taken while status bit 7 is clear and the stored strobe is clear advances the handshake. If ack (bit 6) is set, ack clears. Otherwise both ack and bit 7 become set. Under any other condition a status read leaves status unchanged.
- R8: A data read returns the input latch (0xFF) when control bit 5 is set, and returns the last byte written to offset 0 otherwise.
- R9: After reset, data reads 0xFF, status reads 0xF9, control reads 0xCC, and `irq` and `tx_valid` are low.
- R10: A control write with init set and select clear leaves status, the pending interrupt and the emitted stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Bus access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register offset (low 3 bits decoded) |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (0xFF when no read is active) |
| tx_valid | output | 1 | One-cycle pulse: a byte was sent to the printer |
| tx_byte | output | 8 | Byte sent, valid with tx_valid |
| irq | output | 1 | Level interrupt request |

## Verification
The handshake is driven by a directed walk and then by a random stream. The walk first strobes with the previous strobe clear and then with it already set, which separates an edge-triggered emission from a level-triggered one. Three status reads in a row follow a strobe drop, and they show the ack-clear step apart from the busy-and-ack-set step. The interrupt is tested twice: once with enable newly written and once with enable already stored, which shows that the old control value is the one consulted. Random accesses over all eight offsets, with random control bytes, then mix init-clear, select-clear and direction cases. A behavioural reference compares read data, `irq` and the emitted stream on every clock.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    localparam int BYTE_W  = 8;
    localparam int OFS_W   = 3;

    localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

    localparam logic [BYTE_W-1:0] IDLE_READ  = 8'hFF;
    localparam logic [BYTE_W-1:0] STAT_RESET = 8'hF9;
    localparam logic [BYTE_W-1:0] STAT_INIT  = 8'hD8;
    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'hCC;
    localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
    localparam logic [BYTE_W-1:0] INLATCH_RESET = 8'hFF;

    typedef struct packed {
        logic       not_busy;
        logic       ack;
        logic       paper_out;
        logic       online;
        logic       not_err;
        logic [1:0] spare;
        logic       tmo;
    } stat_t;

    typedef struct packed {
        logic [1:0] fixed;
        logic       dir_in;
        logic       int_en;
        logic       sel;
        logic       init;
        logic       auto_lf;
        logic       strobe;
    } ctrl_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_WR_DATA,
        OP_WR_CTRL,
        OP_WR_NONE,
        OP_RD_DATA,
        OP_RD_STAT,
        OP_RD_CTRL,
        OP_RD_NONE
    } op_t;

    function automatic ctrl_t ctrl_from_bus(input logic [BYTE_W-1:0] v);
        return ctrl_t'(v | CTRL_FORCE);
    endfunction

    function automatic logic printer_pulse(input ctrl_t c);
        return c.init && c.sel && c.strobe;
    endfunction

    function automatic logic printer_release(input ctrl_t c);
        return c.init && c.sel && !c.strobe;
    endfunction

endpackage

// File: rtl/ppc_decode.sv
module ppc_decode
    import ppc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output op_t               op
);
    logic [OFS_W-1:0] ofs;

    generate
        if (ADDR_W > OFS_W) begin : g_wide
            logic [ADDR_W-OFS_W-1:0] upper_unused;
            assign upper_unused = acc_addr[ADDR_W-1:OFS_W];
            assign ofs = acc_addr[OFS_W-1:0];
        end else begin : g_exact
            assign ofs = acc_addr;
        end
    endgenerate

    always_comb begin
        op = OP_IDLE;
        if (acc_valid) begin
            if (acc_write) begin
                unique case (ofs)
                    OFS_DATA: op = OP_WR_DATA;
                    OFS_CTRL: op = OP_WR_CTRL;
                    default:  op = OP_WR_NONE;
                endcase
            end else begin
                unique case (ofs)
                    OFS_DATA: op = OP_RD_DATA;
                    OFS_STAT: op = OP_RD_STAT;
                    OFS_CTRL: op = OP_RD_CTRL;
                    default:  op = OP_RD_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ppc_ctrl_path.sv
module ppc_ctrl_path
    import ppc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_t               op,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic [BYTE_W-1:0] out_latch,
    output logic [BYTE_W-1:0] in_latch,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);
    ctrl_t ctrl_next;
    logic  emit;

    assign ctrl_next = ctrl_from_bus(wdata);
    assign emit = (op == OP_WR_CTRL) && printer_pulse(ctrl_next) && !ctrl_q.strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= ctrl_t'(CTRL_RESET);
            out_latch <= INLATCH_RESET;
            in_latch  <= INLATCH_RESET;
            tx_valid  <= 1'b0;
            tx_byte   <= '0;
        end else begin
            tx_valid <= emit;
            if (emit) tx_byte <= out_latch;
            if (op == OP_WR_DATA) out_latch <= wdata;
            if (op == OP_WR_CTRL) ctrl_q <= ctrl_next;
        end
    end

    // R4: emission is a single-cycle pulse
    p_tx_single_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> !tx_valid);

    // R4: a byte is only sent once the stored strobe is high
    p_tx_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> ctrl_q.strobe && ctrl_q.sel && ctrl_q.init);

    // R2: stored control always has its top two bits set
    p_ctrl_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        $past(op == OP_WR_CTRL) |-> ctrl_q.fixed == 2'b11);
endmodule

// File: rtl/ppc_status_fsm.sv
module ppc_status_fsm
    import ppc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_t               op,
    input  logic [BYTE_W-1:0] wdata,
    input  ctrl_t             ctrl_q,
    output stat_t             stat_q,
    output logic              pend_q
);
    ctrl_t wr_ctrl;
    logic  step_ok;

    assign wr_ctrl = ctrl_from_bus(wdata);
    assign step_ok = !stat_q.not_busy && !ctrl_q.strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= stat_t'(STAT_RESET);
            pend_q <= 1'b0;
        end else begin
            unique case (op)
                OP_WR_CTRL: begin
                    if (!wr_ctrl.init) begin
                        stat_q <= stat_t'(STAT_INIT);
                    end else if (printer_pulse(wr_ctrl)) begin
                        stat_q.not_busy <= 1'b0;
                    end else if (printer_release(wr_ctrl) && ctrl_q.int_en) begin
                        pend_q <= 1'b1;
                    end
                end
                OP_RD_STAT: begin
                    pend_q <= 1'b0;
                    if (step_ok) begin
                        if (stat_q.ack) begin
                            stat_q.ack <= 1'b0;
                        end else begin
                            stat_q.ack      <= 1'b1;
                            stat_q.not_busy <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: a status read always drops the request
    p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_STAT) |=> !pend_q);

    // R5: the request only rises after a control write
    p_irq_source_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(op == OP_WR_CTRL && ctrl_q.int_en));

    // R7: second handshake step restores busy and ack together
    p_hs_restore_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_STAT && step_ok && !stat_q.ack) |=> stat_q.not_busy && stat_q.ack);

    // R1: ignored writes leave status and request untouched
    p_ignored_write_r1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WR_NONE) |=> $stable(stat_q) && $stable(pend_q));
endmodule

// File: rtl/ppc_port.sv
module ppc_port
    import ppc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              irq
);
    op_t               op;
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic              pend_q;
    logic [BYTE_W-1:0] out_latch;
    logic [BYTE_W-1:0] in_latch;

    ppc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .op        (op)
    );

    ppc_ctrl_path u_ctl (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wdata     (acc_wdata),
        .ctrl_q    (ctrl_q),
        .out_latch (out_latch),
        .in_latch  (in_latch),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte)
    );

    ppc_status_fsm u_st (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wdata  (acc_wdata),
        .ctrl_q (ctrl_q),
        .stat_q (stat_q),
        .pend_q (pend_q)
    );

    assign irq = pend_q;

    always_comb begin
        unique case (op)
            OP_RD_DATA: acc_rdata = ctrl_q.dir_in ? in_latch : out_latch;
            OP_RD_STAT: acc_rdata = stat_q;
            OP_RD_CTRL: acc_rdata = ctrl_q;
            default:    acc_rdata = IDLE_READ;
        endcase
    end

    // R1: undecoded offsets read as all ones
    p_undecoded_read_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr[2:0] > 3'd2) |-> acc_rdata == 8'hFF);
endmodule

// File: tb/ppc_port_test.sv
`timescale 1ns/100ps
module ppc_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [2:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ppc_port #(.ADDR_W(3)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    // behavioural reference state
    int m_out, m_in, m_st, m_ct, m_pend, m_txv, m_txb;
    int txq[$];

    always @(posedge clk) begin
        int v;
        if (rst) begin
            m_out = 255; m_in = 255; m_st = 'hF9; m_ct = 'hCC; m_pend = 0; m_txv = 0;
        end else begin
            m_txv = 0;
            if (acc_valid && acc_write && acc_addr == 0) m_out = acc_wdata;
            if (acc_valid && acc_write && acc_addr == 2) begin
                v = acc_wdata | 'hC0;
                if ((v & 4) == 0) m_st = 'hD8;
                else if (v & 8) begin
                    if (v & 1) begin
                        m_st = m_st & 'h7F;
                        if ((m_ct & 1) == 0) begin m_txv = 1; m_txb = m_out; txq.push_back(m_out); end
                    end else if (m_ct & 'h10) m_pend = 1;
                end
                m_ct = v;
            end
            if (acc_valid && !acc_write && acc_addr == 1) begin
                m_pend = 0;
                if ((m_st & 'h80) == 0 && (m_ct & 1) == 0) begin
                    if (m_st & 'h40) m_st = m_st & ~'h40;
                    else m_st = m_st | 'hC0;
                end
            end
        end
    end

    function automatic int exp_rdata();
        if (!acc_valid || acc_write) return 255;
        case (acc_addr)
            0: return (m_ct & 'h20) ? m_in : m_out;
            1: return m_st;
            2: return m_ct;
            default: return 255;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison, away from the edge
    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            string rt;
            case (acc_addr)
                0: rt = "R8 data read";
                1: rt = "R7 status read";
                2: rt = "R2 control read";
                default: rt = "R1 undecoded read";
            endcase
            if (acc_valid && !acc_write) chk(rt, acc_rdata, exp_rdata());
            chk("R5/R6 irq level (R5)", irq, m_pend);
            chk("R4 tx_valid", tx_valid, m_txv);
            if (m_txv) chk("R4 tx_byte", tx_byte, m_txb);
        end
    end

    task automatic access(input bit wr, input int a, input int d);
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_addr = 3'(a); acc_wdata = 8'(d);
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic rd_expect(input int a, input int exp, input string tag);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = 3'(a);
        #1 chk(tag, acc_rdata, exp);
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic idle_expect_irq(input int exp, input string tag);
        @(negedge clk);
        #1 chk(tag, irq, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R9 reset values
        idle_expect_irq(0, "R9 irq after reset");
        chk("R9 tx_valid after reset", tx_valid, 0);
        rd_expect(1, 'hF9, "R9 status reset");
        rd_expect(2, 'hCC, "R9 control reset");
        rd_expect(0, 'hFF, "R9 data reset");
        // R8 data latch vs input latch
        access(1, 0, 'h41);
        rd_expect(0, 'h41, "R8 written byte");
        access(1, 2, 'h2C);
        rd_expect(0, 'hFF, "R8 input latch with dir");
        rd_expect(2, 'hEC, "R2 forced top bits");
        // R4 emission on strobe rise
        access(1, 2, 'h0C);
        access(1, 2, 'h0D);
        chk("R4 one byte emitted", txq.size(), 1);
        rd_expect(1, 'h79, "R4 busy cleared");
        access(1, 2, 'h0D);
        chk("R4 no emit on held strobe", txq.size(), 1);
        rd_expect(1, 'h79, "R7 no advance with strobe held");
        // R7 handshake walk
        access(1, 2, 'h0C);
        rd_expect(1, 'h79, "R7 first read");
        rd_expect(1, 'h39, "R7 ack cleared");
        rd_expect(1, 'hF9, "R7 busy and ack set");
        // R10 select clear does nothing
        access(1, 2, 'h05);
        chk("R10 no emit", txq.size(), 1);
        rd_expect(1, 'hF9, "R10 status unchanged");
        // R5 interrupt uses stored enable
        access(1, 2, 'h1C);
        idle_expect_irq(0, "R5 enable newly written");
        access(1, 2, 'h1C);
        idle_expect_irq(1, "R5 irq raised");
        access(1, 5, 'h00);
        idle_expect_irq(1, "R1 write to offset 5 ignored");
        rd_expect(2, 'hDC, "R1 control unchanged");
        rd_expect(0, 'h41, "R1 data unchanged");
        rd_expect(1, 'hF9, "R6 status read");
        idle_expect_irq(0, "R6 irq cleared");
        // R3 init clear
        access(1, 2, 'h08);
        rd_expect(1, 'hD8, "R3 status reload");
        // R1 undecoded offsets
        for (int a = 3; a < 8; a++) rd_expect(a, 'hFF, "R1 undecoded offset");
        // random stream against the reference
        for (int i = 0; i < 400; i++) begin
            int a;
            a = $urandom_range(0, 7);
            if ($urandom_range(0, 3) == 0) a = 1;
            access($urandom_range(0, 1) == 1, a, $urandom_range(0, 255));
        end
        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule